// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the timing strobes for a multiplexed address/data bus: an address-latch pulse, an active-low code-fetch strobe, and active-low read and write strobes for external data memory. It counts a machine cycle of twelve oscillator clocks and ties every strobe edge to a fixed phase inside that cycle. It also tells the pad logic when the low address byte is on the bus and whether the low byte lane must drive or float.

A data read or write request is sampled only at the last phase of a machine cycle, and its strobe then fills the whole next machine cycle. In that data cycle the second address-latch pulse and both code-fetch pulses are left out. A software bit can silence the address-latch pulses. That bit is ignored while code runs from external memory, during table or data move instructions, and in idle, power-down or emulation mode. Idle and power-down each force fixed levels on the latch and fetch strobes.

Top module: `ext_bus_strobe_seq`

## Requirements
- R1: A phase counter runs 0..11 and wraps to 0. Synchronous reset puts it at phase 0, where the address-latch output is high and both data strobes are high.
- R2: Outside a data cycle, `ale` is high in phases 0-1 and 6-7 of every machine cycle. This gives a 2-clock pulse every 6 clocks.
- R3: Outside a data cycle, and only while `ext_fetch` is 1, `psen_n` is low in phases 3-5 and 9-11. It is high otherwise.
- R4: A request on `dreq_rd` or `dreq_wr` takes effect only if it is present at the clock edge that ends phase 11. A request at any other phase has no effect on any output.
- R5: In the data cycle after an accepted read, `rd_n` is low in phases 3-8 (6 clocks). A write drives `wr_n` low in the same way. If both requests are present, only the read is taken.
- R6: In a data cycle, `ale` pulses only in phases 0-1, and `psen_n` stays high for the whole cycle.
- R7: With `ale_dis` at 1 and no overriding condition, `ale` stays low.
- R8: `ale_dis` has no effect while any of `ext_fetch`, `op_movx`, `op_movc`, `mode_emul`, `mode_idle` or `mode_pdown` is 1.
- R9: In idle, `ale` and `psen_n` are 1. In power-down, both are 0, and power-down takes precedence. In either mode the data strobes stay high, `addr_phase` and `p0_drive` are 0, and requests are not accepted.
- R10: `addr_phase` is 1 in phases 0-2 of a data cycle. Otherwise it is 1 in phases 0-2 and 6-8, and only when `ext_fetch` is 1. `p0_drive` is `addr_phase`, plus phases 3-8 of a write data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_fetch | input | 1 | Code is being fetched from external memory |
| dreq_rd | input | 1 | External data read request |
| dreq_wr | input | 1 | External data write request |
| ale_dis | input | 1 | Software address-latch disable bit |
| op_movx | input | 1 | Data move instruction in progress |
| op_movc | input | 1 | Table read instruction in progress |
| mode_idle | input | 1 | Idle mode |
| mode_pdown | input | 1 | Power-down mode |
| mode_emul | input | 1 | Emulation mode |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Code fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| addr_phase | output | 1 | Low address byte is on the bus |
| p0_drive | output | 1 | 1 = drive low byte lane, 0 = float |

## Verification
All outputs are decoded without further registers from the phase counter and the accepted-request state. Mode and disable inputs therefore act in the same cycle. The phase moves one step at each clock edge. An accepted request changes the strobes in the machine cycle that starts at the edge ending phase 11, and in no other cycle. The bench keeps its own phase count from the reset release, drives inputs at the falling edge, and compares every output one time unit later against values derived from the phase windows. It latches its own copy of a request only at a phase-11 boundary, so each result is checked in the exact cycle it is due.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RD   = 2'd1,
        ACC_WR   = 2'd2
    } acc_e;

    typedef struct packed {
        logic ext_fetch;
        logic ale_dis;
        logic op_movx;
        logic op_movc;
        logic idle;
        logic pdown;
        logic emul;
    } mode_t;

    // True when phase p lies in [start, start+len)
    function automatic logic in_win(input int p, input int start, input int len);
        return (p >= start) && (p < start + len);
    endfunction

endpackage

// File: rtl/bus_phase_ctr.sv
module bus_phase_ctr #(
    parameter int CYCLE_LEN = 12,
    localparam int PW = $clog2(CYCLE_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] phase,
    output logic          last
);
    localparam logic [PW-1:0] LAST_P = PW'(CYCLE_LEN - 1);

    assign last = (phase == LAST_P);

    always_ff @(posedge clk) begin
        if (rst || last) phase <= '0;
        else             phase <= phase + 1'b1;
    end

    assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (phase == LAST_P) |=> (phase == '0));
    assert_range_R1: assert property (@(posedge clk) disable iff (rst)
        phase <= LAST_P);
endmodule

// File: rtl/bus_acc_track.sv
module bus_acc_track
    import ext_bus_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic last,
    input  logic halt,
    input  logic req_rd,
    input  logic req_wr,
    output acc_e acc
);
    always_ff @(posedge clk) begin
        if (rst)            acc <= ACC_NONE;
        else if (last) begin
            if (halt)        acc <= ACC_NONE;
            else if (req_rd) acc <= ACC_RD;
            else if (req_wr) acc <= ACC_WR;
            else             acc <= ACC_NONE;
        end
    end

    assert_boundary_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(acc) |-> $past(last));
endmodule

// File: rtl/bus_strobe_dec.sv
module bus_strobe_dec
    import ext_bus_pkg::*;
#(
    parameter int CYCLE_LEN    = 12,
    parameter int ALE_LEN      = 2,
    parameter int STROBE_START = 3,
    parameter int STROBE_LEN   = 6,
    localparam int PW       = $clog2(CYCLE_LEN),
    localparam int HALF     = CYCLE_LEN / 2,
    localparam int FETCH_LEN = HALF - STROBE_START,
    localparam int ADDR_LEN = ALE_LEN + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] phase,
    input  acc_e          acc,
    input  mode_t         md,
    output logic          ale,
    output logic          psen_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic          addr_phase,
    output logic          p0_drive
);
    int  p;
    logic data_cyc, sleep, ale_win, fetch_win, addr_win, strobe_win, ale_mute;

    always_comb begin
        p          = int'(phase);
        data_cyc   = (acc != ACC_NONE);
        sleep      = md.idle | md.pdown;
        strobe_win = in_win(p, STROBE_START, STROBE_LEN);

        ale_win   = in_win(p, 0, ALE_LEN) |
                    (!data_cyc && in_win(p, HALF, ALE_LEN));
        fetch_win = !data_cyc && md.ext_fetch &&
                    (in_win(p, STROBE_START, FETCH_LEN) ||
                     in_win(p, HALF + STROBE_START, FETCH_LEN));
        addr_win  = data_cyc ? in_win(p, 0, ADDR_LEN)
                             : md.ext_fetch && (in_win(p, 0, ADDR_LEN) ||
                                                in_win(p, HALF, ADDR_LEN));

        ale_mute = md.ale_dis & ~(md.ext_fetch | md.op_movx | md.op_movc |
                                  md.emul | sleep);

        if (md.pdown)     ale = 1'b0;
        else if (md.idle) ale = 1'b1;
        else              ale = ale_win & ~ale_mute;

        if (md.pdown)     psen_n = 1'b0;
        else if (md.idle) psen_n = 1'b1;
        else              psen_n = ~fetch_win;

        rd_n       = ~(!sleep && acc == ACC_RD && strobe_win);
        wr_n       = ~(!sleep && acc == ACC_WR && strobe_win);
        addr_phase = !sleep && addr_win;
        p0_drive   = addr_phase | ~wr_n;
    end

    assert_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));
    assert_rdfall_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n) |-> (p == STROBE_START) || $past(md.idle | md.pdown));
    assert_nofetch_R6: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> psen_n);
    assert_pdown_R9: assert property (@(posedge clk) disable iff (rst)
        md.pdown |-> (!ale && !psen_n && rd_n && wr_n && !p0_drive));
    assert_mute_R7: assert property (@(posedge clk) disable iff (rst)
        (md.ale_dis && !md.ext_fetch && !md.op_movx && !md.op_movc &&
         !md.emul && !md.idle && !md.pdown) |-> !ale);
endmodule

// File: rtl/ext_bus_strobe_seq.sv
module ext_bus_strobe_seq
    import ext_bus_pkg::*;
#(
    parameter int CYCLE_LEN    = 12,
    parameter int ALE_LEN      = 2,
    parameter int STROBE_START = 3,
    parameter int STROBE_LEN   = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_fetch,
    input  logic dreq_rd,
    input  logic dreq_wr,
    input  logic ale_dis,
    input  logic op_movx,
    input  logic op_movc,
    input  logic mode_idle,
    input  logic mode_pdown,
    input  logic mode_emul,
    output logic ale,
    output logic psen_n,
    output logic rd_n,
    output logic wr_n,
    output logic addr_phase,
    output logic p0_drive
);
    localparam int PW = $clog2(CYCLE_LEN);

    logic [PW-1:0] phase;
    logic          last;
    acc_e          acc;
    mode_t         md;

    assign md = '{ext_fetch: ext_fetch, ale_dis: ale_dis, op_movx: op_movx,
                  op_movc: op_movc, idle: mode_idle, pdown: mode_pdown,
                  emul: mode_emul};

    bus_phase_ctr #(.CYCLE_LEN(CYCLE_LEN)) u_ctr (
        .clk(clk), .rst(rst), .phase(phase), .last(last)
    );

    bus_acc_track u_acc (
        .clk(clk), .rst(rst), .last(last),
        .halt(mode_idle | mode_pdown),
        .req_rd(dreq_rd), .req_wr(dreq_wr), .acc(acc)
    );

    bus_strobe_dec #(
        .CYCLE_LEN(CYCLE_LEN), .ALE_LEN(ALE_LEN),
        .STROBE_START(STROBE_START), .STROBE_LEN(STROBE_LEN)
    ) u_dec (
        .clk(clk), .rst(rst), .phase(phase), .acc(acc), .md(md),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr_phase(addr_phase), .p0_drive(p0_drive)
    );
endmodule

// File: tb/tb_ext_bus_strobe_seq.sv
module tb_ext_bus_strobe_seq;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst, ext_fetch, dreq_rd, dreq_wr, ale_dis;
    logic op_movx, op_movc, mode_idle, mode_pdown, mode_emul;
    logic ale, psen_n, rd_n, wr_n, addr_phase, p0_drive;

    int n_chk = 0;
    int n_err = 0;
    int bph   = 0;   // bench phase
    int bacc  = 0;   // 0 none, 1 read, 2 write

    always #(CLK_P/2) clk = ~clk;

    ext_bus_strobe_seq dut (
        .clk(clk), .rst(rst), .ext_fetch(ext_fetch), .dreq_rd(dreq_rd),
        .dreq_wr(dreq_wr), .ale_dis(ale_dis), .op_movx(op_movx),
        .op_movc(op_movc), .mode_idle(mode_idle), .mode_pdown(mode_pdown),
        .mode_emul(mode_emul), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
        .wr_n(wr_n), .addr_phase(addr_phase), .p0_drive(p0_drive)
    );

    task automatic chk(input string tag, input string nm, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s phase=%0d acc=%0d got %b expected %b at %0t",
                     tag, nm, bph, bacc, got, exp, $time);
        end
    endtask

    task automatic check_all();
        logic sl, ovr, mute, e_ale, e_psen, e_rd, e_wr, e_addr, e_p0;
        string t_ale, t_psen, t_rd;
        sl   = mode_idle | mode_pdown;
        ovr  = ext_fetch | op_movx | op_movc | mode_emul | sl;
        mute = ale_dis & ~ovr;
        e_ale = (bph < 2) || (bacc == 0 && bph >= 6 && bph < 8);
        e_ale = mode_pdown ? 1'b0 : mode_idle ? 1'b1 : (e_ale & ~mute);
        e_psen = !(ext_fetch && bacc == 0 &&
                   ((bph >= 3 && bph < 6) || bph >= 9));
        e_psen = mode_pdown ? 1'b0 : mode_idle ? 1'b1 : e_psen;
        e_rd = !(!sl && bacc == 1 && bph >= 3 && bph < 9);
        e_wr = !(!sl && bacc == 2 && bph >= 3 && bph < 9);
        e_addr = !sl && ((bacc != 0) ? (bph < 3)
                         : (ext_fetch && (bph < 3 || (bph >= 6 && bph < 9))));
        e_p0 = e_addr || !e_wr;
        t_ale  = sl ? "R9" : mute ? "R7" : (ale_dis ? "R8" : (bacc != 0 ? "R6" : "R2"));
        t_psen = sl ? "R9" : (bacc != 0 ? "R6" : "R3");
        t_rd   = sl ? "R9" : (bacc != 0 ? "R5" : "R4");
        chk(t_ale, "ale", ale, e_ale);
        chk(t_psen, "psen_n", psen_n, e_psen);
        chk(t_rd, "rd_n", rd_n, e_rd);
        chk(t_rd, "wr_n", wr_n, e_wr);
        chk("R10", "addr_phase", addr_phase, e_addr);
        chk("R10", "p0_drive", p0_drive, e_p0);
    endtask

    task automatic advance();
        if (bph == 11)
            bacc = (mode_idle || mode_pdown) ? 0 : dreq_rd ? 1 : dreq_wr ? 2 : 0;
        bph = (bph + 1) % 12;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1; ext_fetch = 0; dreq_rd = 0; dreq_wr = 0; ale_dis = 0;
        op_movx = 0; op_movc = 0; mode_idle = 0; mode_pdown = 0; mode_emul = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state at phase 0
        chk("R1", "ale", ale, 1'b1);
        chk("R1", "rd_n", rd_n, 1'b1);
        chk("R1", "wr_n", wr_n, 1'b1);
        chk("R1", "psen_n", psen_n, 1'b1);
        advance();
        for (int s = 0; s < 32; s++) begin
            int sel;
            sel = s >> 2;
            for (int c = 0; c < 120; c++) begin
                int m;
                @(negedge clk);
                m = c / 12;
                ext_fetch  = s[0];
                ale_dis    = s[1];
                op_movx    = (sel == 1);
                op_movc    = (sel == 2);
                mode_emul  = (sel == 3);
                mode_idle  = (sel == 4) && (m >= 2);
                mode_pdown = (sel == 5) && (m >= 2);
                if (sel == 6) begin
                    // R4: requests away from the boundary must be ignored
                    dreq_rd = (bph != 11);
                    dreq_wr = (bph != 11);
                end else if (sel == 7) begin
                    dreq_rd = 1'b1;
                    dreq_wr = 1'b1;
                end else begin
                    dreq_rd = (m % 3 == 0);
                    dreq_wr = (m % 2 == 1);
                end
                #1;
                check_all();
                advance();
            end
        end
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule